// File: doc/BRIEF.md
# Mixed Page-Size Translation Cache

This block caches virtual-to-physical translations of three page sizes (4 KiB, 64 KiB and 1 MiB) in a set-associative array of 8 ways by 64 sets. A client presents a virtual address on a lookup stream and one cycle later receives a response carrying hit, the translated physical address and the page-size code. A page walker writes its results through a fill stream. A control port removes entries, either all at once or by comparing one 4 KiB virtual page against every way of the set that page indexes.

The set is always chosen by virtual address bits 17:12, whatever the page size. A large page is therefore cached only in the set of the address that caused its fill, and other addresses inside the same large page may miss and be filled again into other sets. To remove a 64 KiB page completely, software issues 16 per-page invalidates at successive 4 KiB addresses; for a 1 MiB page, 64 invalidates covering one full run of set indices are enough.

Only one operation is accepted per cycle. Invalidate beats fill, and fill beats lookup. The lookup stream follows valid/ready rules: a request transfers on a cycle where `lk_valid` and `lk_ready` are both high. The response stays valid and unchanged until `rsp_ready` is high. `lk_ready` is low while an earlier response waits, and also while a fill or invalidate is being presented. `fill_ready` is low only while an invalidate is presented. The invalidate port has no handshake and always takes effect in the cycle it is presented.

Top module: `tlb_mixed`

## Requirements
- R1: After reset no entry is valid. Every lookup misses, `rsp_valid` is low and `lk_ready` is high.
- R2: A lookup that matches exactly one valid way returns `rsp_hit`=1 and that way's size code in `rsp_size` (0 = 4 KiB, 1 = 64 KiB, 2 = 1 MiB). `rsp_pa` is built from three parts: the stored frame number, the virtual page bits below the page size (none, 4 or 8 bits), and the 12-bit page offset. A miss returns `rsp_hit`=0.
- R3: The set index is virtual page bits 5:0 (address bits 17:12). A lookup inside a cached large page whose address bits 17:12 differ from those of the filling address misses.
- R4: A fill writes the lowest-numbered invalid way of its set. When the set is full, it writes the least-recently-used way. Both a fill and a lookup hit make the way concerned the most recently used.
- R5: A per-page invalidate (`inv_all`=0) clears every valid way of the set indexed by `inv_vpn` whose tag equals `inv_vpn` masked to that way's page size, for any size. Other ways stay valid.
- R6: A flush (`inv_all`=1) clears every entry in the single cycle it is presented.
- R7: When more than one valid way matches a lookup, the response carries `rsp_multi`=1 and `rsp_hit`=0.
- R8: While `inv_valid` is high, `fill_ready` and `lk_ready` are low. While `fill_valid` is high, `lk_ready` is low. A fill or lookup that is not accepted has no effect.
- R9: A response held with `rsp_ready` low keeps all its fields stable, and `lk_ready` stays low until the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle if valid |
| lk_va | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | Exactly one way matched |
| rsp_multi | output | 1 | More than one way matched |
| rsp_pa | output | PA_W | Translated physical address (zero on miss) |
| rsp_size | output | 2 | Size code of the hitting entry |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill accepted this cycle if valid |
| fill_vpn | input | VA_W-12 | Virtual page number of the new mapping |
| fill_pfn | input | PA_W-12 | Physical frame number of the new mapping |
| fill_size | input | 2 | Size code of the new mapping |
| inv_valid | input | 1 | Invalidate command this cycle |
| inv_all | input | 1 | 1: clear everything, 0: per-page removal |
| inv_vpn | input | VA_W-12 | 4 KiB virtual page to remove |

## Verification
The hardest states to reach from the ports are a completely full set, where replacement order becomes visible, and two ways of one set matching the same address. The stimulus fills one set with eight small pages whose addresses are 256 KiB apart, so they all share bits 17:12. It then touches the oldest page with a hit before a ninth fill, and checks that the second-oldest page was displaced and the touched one survived. A duplicate match is produced by filling a 4 KiB and a 1 MiB mapping at the same address, which must raise the multi-hit flag; one per-page invalidate must then clear both.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int PG_SHIFT = 12;  // small page offset bits
  localparam int MID_BITS = 4;   // 64 KiB page = 16 small pages
  localparam int BIG_BITS = 8;   // 1 MiB page = 256 small pages

  typedef enum logic [1:0] {
    PG_SMALL = 2'd0,
    PG_MID   = 2'd1,
    PG_BIG   = 2'd2,
    PG_RSVD  = 2'd3
  } pg_size_e;

  // Number of virtual page bits that fall inside a page of the given size.
  function automatic logic [3:0] pg_low_bits(input logic [1:0] sz);
    case (sz)
      PG_SMALL: pg_low_bits = 4'd0;
      PG_MID:   pg_low_bits = 4'(MID_BITS);
      default:  pg_low_bits = 4'(BIG_BITS);
    endcase
  endfunction

endpackage

// File: rtl/tlb_way_cmp.sv
module tlb_way_cmp #(
  parameter int WAYS  = 8,
  parameter int VPN_W = 20
) (
  input  logic [WAYS-1:0]            ent_vld,
  input  logic [WAYS-1:0][VPN_W-1:0] ent_tag,
  input  logic [WAYS-1:0][1:0]       ent_sz,
  input  logic [VPN_W-1:0]           q_vpn,
  output logic [WAYS-1:0]            match
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [VPN_W-1:0] keep_msk;
    assign keep_msk = {VPN_W{1'b1}} << tlb_pkg::pg_low_bits(ent_sz[w]);
    assign match[w] = ent_vld[w] && ((q_vpn & keep_msk) == ent_tag[w]);
  end

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int SET_W = 6,
  parameter int WAY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] q_set,
  output logic [WAY_W-1:0] lru_way
);

  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  // Per set, the ages form a permutation of 0..WAYS-1; 0 is the newest.
  logic [WAY_W-1:0] age [SETS][WAYS];
  logic [WAY_W-1:0] touched_age;

  assign touched_age = age[touch_set][touch_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age[touch_set][w] <= '0;
        else if (age[touch_set][w] < touched_age)
          age[touch_set][w] <= age[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age[q_set][w] == OLDEST) lru_way = WAY_W'(w);
  end

endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int SET_W = 6,
  parameter int WAY_W = 3,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush_all,
  input  logic                       clr_en,
  input  logic [SET_W-1:0]           clr_set,
  input  logic [WAYS-1:0]            clr_mask,
  input  logic                       wr_en,
  input  logic [SET_W-1:0]           wr_set,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic [VPN_W-1:0]           wr_tag,
  input  logic [1:0]                 wr_sz,
  input  logic [PFN_W-1:0]           wr_ppn,
  input  logic [SET_W-1:0]           rd_set,
  output logic [WAYS-1:0]            rd_vld,
  output logic [WAYS-1:0][VPN_W-1:0] rd_tag,
  output logic [WAYS-1:0][1:0]       rd_sz,
  output logic [WAYS-1:0][PFN_W-1:0] rd_ppn
);

  logic [WAYS-1:0]            vld_mem [SETS];
  logic [WAYS-1:0][VPN_W-1:0] tag_mem [SETS];
  logic [WAYS-1:0][1:0]       sz_mem  [SETS];
  logic [WAYS-1:0][PFN_W-1:0] ppn_mem [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
    end else begin
      if (flush_all) begin
        for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
      end else if (clr_en) begin
        vld_mem[clr_set] <= vld_mem[clr_set] & ~clr_mask;
      end
      if (wr_en) vld_mem[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set][wr_way] <= wr_tag;
      sz_mem[wr_set][wr_way]  <= wr_sz;
      ppn_mem[wr_set][wr_way] <= wr_ppn;
    end
  end

  assign rd_vld = vld_mem[rd_set];
  assign rd_tag = tag_mem[rd_set];
  assign rd_sz  = sz_mem[rd_set];
  assign rd_ppn = ppn_mem[rd_set];

endmodule

// File: rtl/tlb_mixed.sv
module tlb_mixed #(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int WAYS = 8,
  parameter int SETS = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lk_valid,
  output logic                          lk_ready,
  input  logic [VA_W-1:0]               lk_va,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic                          rsp_hit,
  output logic                          rsp_multi,
  output logic [PA_W-1:0]               rsp_pa,
  output logic [1:0]                    rsp_size,
  input  logic                          fill_valid,
  output logic                          fill_ready,
  input  logic [VA_W-tlb_pkg::PG_SHIFT-1:0] fill_vpn,
  input  logic [PA_W-tlb_pkg::PG_SHIFT-1:0] fill_pfn,
  input  logic [1:0]                    fill_size,
  input  logic                          inv_valid,
  input  logic                          inv_all,
  input  logic [VA_W-tlb_pkg::PG_SHIFT-1:0] inv_vpn
);

  localparam int PG_SHIFT = tlb_pkg::PG_SHIFT;
  localparam int VPN_W    = VA_W - PG_SHIFT;
  localparam int PFN_W    = PA_W - PG_SHIFT;
  localparam int SET_W    = $clog2(SETS);
  localparam int WAY_W    = $clog2(WAYS);

  // ---------------- operation select ----------------
  logic do_fill, do_lk;
  assign fill_ready = !inv_valid;
  assign lk_ready   = !inv_valid && !fill_valid && (!rsp_valid || rsp_ready);
  assign do_fill    = fill_valid && !inv_valid;
  assign do_lk      = lk_valid && lk_ready;

  logic [VPN_W-1:0] lk_vpn, q_vpn;
  logic [SET_W-1:0] acc_set;
  assign lk_vpn = lk_va[VA_W-1:PG_SHIFT];
  assign q_vpn  = inv_valid ? inv_vpn : lk_vpn;

  always_comb begin
    if (inv_valid)       acc_set = inv_vpn[SET_W-1:0];
    else if (fill_valid) acc_set = fill_vpn[SET_W-1:0];
    else                 acc_set = lk_vpn[SET_W-1:0];
  end

  // ---------------- storage and compare ----------------
  logic [WAYS-1:0]            rd_vld;
  logic [WAYS-1:0][VPN_W-1:0] rd_tag;
  logic [WAYS-1:0][1:0]       rd_sz;
  logic [WAYS-1:0][PFN_W-1:0] rd_ppn;
  logic [WAYS-1:0]            match;

  logic [WAY_W-1:0] victim, lru_way, free_way, hit_way;
  logic [VPN_W-1:0] fill_tag;
  logic [PFN_W-1:0] fill_ppn;

  assign fill_tag = fill_vpn & ({VPN_W{1'b1}} << tlb_pkg::pg_low_bits(fill_size));
  assign fill_ppn = fill_pfn & ({PFN_W{1'b1}} << tlb_pkg::pg_low_bits(fill_size));

  tlb_store #(
    .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W),
    .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush_all(inv_valid && inv_all),
    .clr_en   (inv_valid && !inv_all),
    .clr_set  (acc_set),
    .clr_mask (match),
    .wr_en    (do_fill),
    .wr_set   (acc_set),
    .wr_way   (victim),
    .wr_tag   (fill_tag),
    .wr_sz    (fill_size),
    .wr_ppn   (fill_ppn),
    .rd_set   (acc_set),
    .rd_vld   (rd_vld),
    .rd_tag   (rd_tag),
    .rd_sz    (rd_sz),
    .rd_ppn   (rd_ppn)
  );

  tlb_way_cmp #(.WAYS(WAYS), .VPN_W(VPN_W)) u_cmp (
    .ent_vld(rd_vld),
    .ent_tag(rd_tag),
    .ent_sz (rd_sz),
    .q_vpn  (q_vpn),
    .match  (match)
  );

  // ---------------- replacement ----------------
  logic any_free, hit_one, multi;

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!rd_vld[w]) free_way = WAY_W'(w);
  end

  assign any_free = !(&rd_vld);
  assign victim   = any_free ? free_way : lru_way;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) hit_way = WAY_W'(w);
  end

  assign multi   = $countones(match) > 1;
  assign hit_one = (|match) && !multi;

  tlb_lru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .touch_en (do_fill || (do_lk && hit_one)),
    .touch_set(acc_set),
    .touch_way(do_fill ? victim : hit_way),
    .q_set    (acc_set),
    .lru_way  (lru_way)
  );

  // ---------------- address composition ----------------
  logic [1:0]       sel_sz;
  logic [PFN_W-1:0] sel_ppn, hit_pfn;
  logic [VPN_W-1:0] inside_msk;

  assign sel_sz     = rd_sz[hit_way];
  assign sel_ppn    = rd_ppn[hit_way];
  assign inside_msk = ~({VPN_W{1'b1}} << tlb_pkg::pg_low_bits(sel_sz));
  assign hit_pfn    = sel_ppn | PFN_W'(lk_vpn & inside_msk);

  // ---------------- response register ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_pa    <= '0;
      rsp_size  <= '0;
    end else if (do_lk) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= hit_one;
      rsp_multi <= multi;
      rsp_pa    <= hit_one ? {hit_pfn, lk_va[PG_SHIFT-1:0]} : '0;
      rsp_size  <= hit_one ? sel_sz : 2'd0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/tlb_mixed_chk.sv
module tlb_mixed_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          lk_valid,
  input logic                          lk_ready,
  input logic [VA_W-1:0]               lk_va,
  input logic                          rsp_valid,
  input logic                          rsp_ready,
  input logic                          rsp_hit,
  input logic                          rsp_multi,
  input logic [PA_W-1:0]               rsp_pa,
  input logic                          fill_valid,
  input logic                          fill_ready,
  input logic [VA_W-tlb_pkg::PG_SHIFT-1:0] fill_vpn,
  input logic                          inv_valid,
  input logic                          inv_all
);

  localparam int PG_SHIFT = tlb_pkg::PG_SHIFT;

  // R7: a duplicate match is never also reported as a hit
  assert_hit_multi_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_multi));

  // R9: a stalled response holds its contents
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_hit)
                                   && $stable(rsp_multi)));

  // R8: invalidate blocks both other ports
  assert_inv_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (!fill_ready && !lk_ready));

  // R6: the lookup right after a flush finds nothing
  assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_all) ##1 (lk_valid && lk_ready) |=> (!rsp_hit && !rsp_multi));

  // R2: a fill is visible to a lookup of the same page on the next cycle
  assert_fill_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) ##1
    (lk_valid && lk_ready && (lk_va[VA_W-1:PG_SHIFT] == $past(fill_vpn)))
    |=> (rsp_hit || rsp_multi));

endmodule

bind tlb_mixed tlb_mixed_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_ready  (lk_ready),
  .lk_va     (lk_va),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_hit   (rsp_hit),
  .rsp_multi (rsp_multi),
  .rsp_pa    (rsp_pa),
  .fill_valid(fill_valid),
  .fill_ready(fill_ready),
  .fill_vpn  (fill_vpn),
  .inv_valid (inv_valid),
  .inv_all   (inv_all)
);

// File: tb/tlb_mixed_tb.sv
module tlb_mixed_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_va = '0;
  logic        rsp_valid, rsp_hit, rsp_multi;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_size;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [1:0]  fill_size = '0;
  logic        inv_valid = 1'b0;
  logic        inv_all = 1'b0;
  logic [19:0] inv_vpn = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  tlb_mixed u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_va(lk_va),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_multi(rsp_multi), .rsp_pa(rsp_pa), .rsp_size(rsp_size),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_size(fill_size),
    .inv_valid(inv_valid), .inv_all(inv_all), .inv_vpn(inv_vpn)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = va[31:12]; fill_pfn = pa[31:12]; fill_size = sz;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_inv(input bit all, input logic [31:0] va);
    @(negedge clk);
    inv_valid = 1'b1; inv_all = all; inv_vpn = va[31:12];
    @(negedge clk);
    inv_valid = 1'b0; inv_all = 1'b0;
  endtask

  task automatic do_lookup(input logic [31:0] va, output logic hit, output logic multi,
                           output logic [31:0] pa, output logic [1:0] sz);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va;
    @(negedge clk);
    lk_valid = 1'b0;
    hit = rsp_hit; multi = rsp_multi; pa = rsp_pa; sz = rsp_size;
  endtask

  // op: 0 fill, 1 lookup, 2 per-page invalidate, 3 flush
  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] va;
    logic [31:0] pa;
    logic [1:0]  sz;
    logic        hit;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 32'h0000_3000, 32'h0000_0000, 2'd0, 1'b0, 4'd1},  // R1 empty
    '{2'd0, 32'h0000_3000, 32'h8000_5000, 2'd0, 1'b0, 4'd2},
    '{2'd1, 32'h0000_3abc, 32'h8000_5abc, 2'd0, 1'b1, 4'd2},  // R2 small
    '{2'd0, 32'h0012_0000, 32'h4567_0000, 2'd1, 1'b0, 4'd2},
    '{2'd1, 32'h0012_0123, 32'h4567_0123, 2'd1, 1'b1, 4'd2},  // R2 mid
    '{2'd1, 32'h0012_1004, 32'h0000_0000, 2'd0, 1'b0, 4'd3},  // R3 other set
    '{2'd0, 32'h0340_5000, 32'h9a00_0000, 2'd2, 1'b0, 4'd2},
    '{2'd1, 32'h0344_5678, 32'h9a04_5678, 2'd2, 1'b1, 4'd2},  // R2 big
    '{2'd1, 32'h034f_5678, 32'h0000_0000, 2'd0, 1'b0, 4'd3},  // R3 other set
    '{2'd2, 32'h0004_3000, 32'h0000_0000, 2'd0, 1'b0, 4'd5},
    '{2'd1, 32'h0000_3010, 32'h8000_5010, 2'd0, 1'b1, 4'd5},  // R5 untouched
    '{2'd2, 32'h034c_5000, 32'h0000_0000, 2'd0, 1'b0, 4'd5},
    '{2'd1, 32'h0340_5000, 32'h0000_0000, 2'd0, 1'b0, 4'd5},  // R5 big removed
    '{2'd2, 32'h0000_3000, 32'h0000_0000, 2'd0, 1'b0, 4'd5},
    '{2'd1, 32'h0000_3000, 32'h0000_0000, 2'd0, 1'b0, 4'd5},  // R5 small removed
    '{2'd1, 32'h0012_0fff, 32'h4567_0fff, 2'd1, 1'b1, 4'd2},
    '{2'd3, 32'h0000_0000, 32'h0000_0000, 2'd0, 1'b0, 4'd6},
    '{2'd1, 32'h0012_0000, 32'h0000_0000, 2'd0, 1'b0, 4'd6},  // R6 flushed
    '{2'd1, 32'h0344_5000, 32'h0000_0000, 2'd0, 1'b0, 4'd6}   // R6 flushed
  };

  function automatic logic [31:0] set_va(input int k);
    return (32'h10 + 32'(k) * 32'h40) << 12;  // all index set 0x10
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic h, m;
    logic [31:0] pa, pa0;
    logic [1:0] sz;
    string tag;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check(lk_ready == 1'b1, "R1 lk_ready", 32'(lk_ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      case (VEC[i].op)
        2'd0: do_fill(VEC[i].va, VEC[i].pa, VEC[i].sz);
        2'd2: do_inv(1'b0, VEC[i].va);
        2'd3: do_inv(1'b1, VEC[i].va);
        default: begin
          do_lookup(VEC[i].va, h, m, pa, sz);
          check(h == VEC[i].hit, {tag, " hit"}, 32'(h), 32'(VEC[i].hit));
          if (VEC[i].hit) begin
            check(pa == VEC[i].pa, {tag, " pa"}, pa, VEC[i].pa);
            check(sz == VEC[i].sz, {tag, " size"}, 32'(sz), 32'(VEC[i].sz));
          end
        end
      endcase
    end

    // R4: fill a whole set, touch the oldest, then force a replacement
    for (int k = 0; k < 8; k++) do_fill(set_va(k), 32'h1000_0000 + (32'(k) << 12), 2'd0);
    do_lookup(set_va(0), h, m, pa, sz);
    check(h == 1'b1, "R4 touch oldest", 32'(h), 32'd1);
    do_fill(set_va(8), 32'h1000_8000, 2'd0);
    do_lookup(set_va(1), h, m, pa, sz);
    check(h == 1'b0, "R4 lru evicted", 32'(h), 32'd0);
    do_lookup(set_va(0), h, m, pa, sz);
    check(h == 1'b1 && pa == 32'h1000_0000, "R4 touched kept", pa, 32'h1000_0000);
    do_lookup(set_va(8), h, m, pa, sz);
    check(h == 1'b1 && pa == 32'h1000_8000, "R4 new entry", pa, 32'h1000_8000);
    do_lookup(set_va(2), h, m, pa, sz);
    check(h == 1'b1 && pa == 32'h1000_2000, "R4 others kept", pa, 32'h1000_2000);

    // R7: overlapping small and big mappings at one address
    do_fill(32'h0050_0000, 32'h1111_1000, 2'd0);
    do_fill(32'h0050_0000, 32'h2220_0000, 2'd2);
    do_lookup(32'h0050_0000, h, m, pa, sz);
    check(m == 1'b1, "R7 multi flag", 32'(m), 32'd1);
    check(h == 1'b0, "R7 no hit", 32'(h), 32'd0);
    // R5: one per-page invalidate removes both sizes
    do_inv(1'b0, 32'h0050_0000);
    do_lookup(32'h0050_0000, h, m, pa, sz);
    check(h == 1'b0 && m == 1'b0, "R5 both sizes removed", {30'd0, h, m}, 32'd0);

    // R8: invalidate beats fill and lookup
    @(negedge clk);
    inv_valid = 1'b1; inv_all = 1'b0; inv_vpn = 20'hfff00;
    fill_valid = 1'b1; fill_vpn = 20'h00777; fill_pfn = 20'h12345; fill_size = 2'd0;
    lk_valid = 1'b1; lk_va = 32'h0000_0000;
    #1;
    check(fill_ready == 1'b0, "R8 fill blocked", 32'(fill_ready), 32'd0);
    check(lk_ready == 1'b0, "R8 lookup blocked", 32'(lk_ready), 32'd0);
    @(negedge clk);
    inv_valid = 1'b0; fill_valid = 1'b0; lk_valid = 1'b0;
    check(rsp_valid == 1'b0, "R8 lookup not taken", 32'(rsp_valid), 32'd0);
    do_lookup(32'h0077_7000, h, m, pa, sz);
    check(h == 1'b0, "R8 fill dropped", 32'(h), 32'd0);
    // R8: fill beats lookup
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'h00777; fill_pfn = 20'h12345; fill_size = 2'd0;
    lk_valid = 1'b1; lk_va = 32'h0077_7000;
    #1;
    check(fill_ready == 1'b1 && lk_ready == 1'b0, "R8 fill over lookup",
          {30'd0, fill_ready, lk_ready}, 32'd2);
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    check(rsp_valid == 1'b0, "R8 lookup held off", 32'(rsp_valid), 32'd0);
    do_lookup(32'h0077_7abc, h, m, pa, sz);
    check(h == 1'b1 && pa == 32'h1234_5abc, "R8 fill taken", pa, 32'h1234_5abc);

    // R9: back-pressure on the response
    @(negedge clk);
    rsp_ready = 1'b0; lk_valid = 1'b1; lk_va = set_va(8);
    @(negedge clk);
    lk_valid = 1'b0; pa0 = rsp_pa;
    check(rsp_valid == 1'b1 && pa0 == 32'h1000_8000, "R9 response", pa0, 32'h1000_8000);
    @(negedge clk);
    check(rsp_valid == 1'b1 && rsp_pa == pa0, "R9 held", rsp_pa, pa0);
    check(lk_ready == 1'b0, "R9 lk_ready low", 32'(lk_ready), 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 released", 32'(rsp_valid), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule